// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator

This block drives one pulse-width modulated output from a small word-addressed register port. Software writes a period and an on-time, both counted in divided clock ticks, and then sets a control word. That word chooses the operating mode, the output level during the on-time and while the channel is stopped, a two-stage clock divider, and a repeat count for single-burst operation.

The clock divider has two stages. The first stage is a power-of-two prescaler. The second stage is optional and divides by twice an 8-bit scale value, where a scale of zero means a divide by 512. In continuous mode the tick counter wraps forever. In one-shot mode the block emits a set number of periods, then clears its own enable bit and returns to the idle level.

The period and on-time registers feed working copies. These copies load only when the channel starts or at the end of a period, so a cycle on the output never mixes old and new settings. Capture mode can be selected but is not built: selecting it holds the pin at the idle level.

Top module: `pwm_gen`

## Requirements
- R1: After reset, reads of the four registers (word offsets 0x0 tick counter, 0x4 period, 0x8 on-time, 0xC control) return 0 and `pwm_out` is 0.
- R2: Period and on-time keep their low 16 bits (upper bits read 0). The control word keeps all 32 bits. `bus_rdata` shows the addressed register one clock after the address is applied.
- R3: In continuous mode (control bit 0 = 1, bits 2:1 = 1), the tick counter runs from 0 to period-1 and wraps. The output equals control bit 3 while the counter is below the on-time, and its inverse otherwise. A period of 0 behaves as 1.
- R4: An on-time equal to or above the period keeps the output at the bit 3 level all the time. An on-time of 0 keeps it at the inverse level all the time.
- R5: While the channel is not generating, `pwm_out` equals control bit 4.
- R6: Control bits 14:12 give an exponent p: one tick occurs every 2^p clocks.
- R7: When control bit 9 is set, each tick is stretched by a further factor of 2×(bits 23:16), and a value of 0 there gives a factor of 512.
- R8: In one-shot mode (bits 2:1 = 0), the block produces (bits 31:24)+1 periods. Hardware then clears control bit 0 and the output goes to the bit 4 level.
- R9: Period and on-time writes made while running take effect only at the next period boundary or at the next start.
- R10: Mode values 2 and 3 never generate. The output stays at the bit 4 level and the tick counter stays 0.
- R11: Offset 0x0 reads the live tick count, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register (word aligned) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
Some properties are checked by assertions on every cycle:
- the tick counter stays inside the working period;
- the working on-time changes only at a wrap or a start;
- the pin sits at the idle level whenever the channel was not generating;
- a completed burst clears the enable bit.

The bench's scenarios cover the rest. It measures the on-time ratio over whole periods for each divider setting, using both output polarities and the saturating on-time values. It also shows that the register port reads back correctly, that one-shot bursts have the right length, that counter writes are ignored, and that an on-time change is deferred to the next boundary.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int DATA_W  = 32;
  localparam int PRE_W   = 3;
  localparam int SCL_W   = 8;
  localparam int RPT_W   = 8;

  localparam logic [1:0] WIX_CNT  = 2'd0;
  localparam logic [1:0] WIX_PER  = 2'd1;
  localparam logic [1:0] WIX_DUTY = 2'd2;
  localparam logic [1:0] WIX_CTRL = 2'd3;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_CONT = 2'd1,
    MODE_CAPT = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic             en;
    mode_e            mode;
    logic             act_lvl;
    logic             idle_lvl;
    logic             slow_sel;
    logic [PRE_W-1:0] pre;
    logic [SCL_W-1:0] scale;
    logic [RPT_W-1:0] rpt;
  } ctrl_t;
endpackage

// File: rtl/pwm_gen_regs.sv
module pwm_gen_regs
  import pwm_gen_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_live,
  input  logic              burst_done,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  duty,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic              hit;
  logic [1:0]        wix;

  assign hit = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
  assign wix = addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      duty   <= '0;
      ctrl_q <= '0;
    end else begin
      if (we && hit && wix == WIX_PER)  period <= wdata[CNT_W-1:0];
      if (we && hit && wix == WIX_DUTY) duty   <= wdata[CNT_W-1:0];
      if (we && hit && wix == WIX_CTRL) ctrl_q <= wdata;
      else if (burst_done)              ctrl_q[0] <= 1'b0;
    end
  end

  assign ctrl.en       = ctrl_q[0];
  assign ctrl.mode     = mode_e'(ctrl_q[2:1]);
  assign ctrl.act_lvl  = ctrl_q[3];
  assign ctrl.idle_lvl = ctrl_q[4];
  assign ctrl.slow_sel = ctrl_q[9];
  assign ctrl.pre      = ctrl_q[12 +: PRE_W];
  assign ctrl.scale    = ctrl_q[16 +: SCL_W];
  assign ctrl.rpt      = ctrl_q[24 +: RPT_W];

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (!hit) rdata <= '0;
    else begin
      case (wix)
        WIX_CNT:  rdata <= {{PAD_W{1'b0}}, cnt_live};
        WIX_PER:  rdata <= {{PAD_W{1'b0}}, period};
        WIX_DUTY: rdata <= {{PAD_W{1'b0}}, duty};
        default:  rdata <= ctrl_q;
      endcase
    end
  end

  // R8: a finished burst leaves the enable bit clear unless software wrote control
  p_done_clears_en_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(burst_done) && !$past(we && hit && wix == WIX_CTRL)) |-> !ctrl_q[0]);
endmodule

// File: rtl/pwm_gen_tick.sv
module pwm_gen_tick
  import pwm_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic             slow_sel,
  input  logic [SCL_W-1:0] scale,
  output logic             tick
);
  localparam int PC_W = (1 << PRE_W) - 1;
  localparam int SC_W = SCL_W + 1;

  logic [PC_W-1:0] pre_cnt, pre_lim;
  logic [SC_W-1:0] scl_cnt, scl_lim;
  logic            pre_tick;

  assign pre_lim  = ({{(PC_W-1){1'b0}}, 1'b1} << pre) - 1'b1;
  assign pre_tick = run && (pre_cnt == pre_lim);

  always_comb begin
    if (!slow_sel)          scl_lim = '0;
    else if (scale == '0)   scl_lim = '1;
    else                    scl_lim = {scale, 1'b0} - 1'b1;
  end

  assign tick = pre_tick && (scl_cnt == scl_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      scl_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) scl_cnt <= tick ? '0 : scl_cnt + 1'b1;
    end
  end

  // R6: with a nonzero exponent held steady, ticks never come back to back
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && pre != '0) |=> (!tick || !$stable(pre)));
endmodule

// File: rtl/pwm_gen_core.sv
module pwm_gen_core
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             tick,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             burst_done,
  output logic             pwm_out
);
  logic [CNT_W-1:0] per_act, duty_act, per_eff;
  logic [RPT_W-1:0] rpt_cnt;
  logic             gen_mode, at_end, one_shot;

  assign one_shot = (ctrl.mode == MODE_ONCE);
  assign gen_mode = ctrl.en && (one_shot || ctrl.mode == MODE_CONT);
  assign per_eff  = (per_act == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : per_act;
  assign at_end   = (cnt >= per_eff - 1'b1);
  assign burst_done = gen_mode && run && tick && at_end && one_shot && (rpt_cnt == ctrl.rpt);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt      <= '0;
      per_act  <= '0;
      duty_act <= '0;
      rpt_cnt  <= '0;
    end else if (!gen_mode) begin
      run     <= 1'b0;
      cnt     <= '0;
      rpt_cnt <= '0;
    end else if (!run) begin
      run      <= 1'b1;
      cnt      <= '0;
      per_act  <= period;
      duty_act <= duty;
      rpt_cnt  <= '0;
    end else if (tick) begin
      if (at_end) begin
        cnt      <= '0;
        per_act  <= period;
        duty_act <= duty;
        if (burst_done) run <= 1'b0;
        else if (one_shot) rpt_cnt <= rpt_cnt + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else if (run && gen_mode) pwm_out <= (cnt < duty_act) ? ctrl.act_lvl : ~ctrl.act_lvl;
    else pwm_out <= ctrl.idle_lvl;
  end

  // R3: the counter never leaves the working period
  p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < per_eff));
  // R9: working on-time only reloads at a wrap or a start
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && !$past(tick && at_end)) |-> $stable(duty_act));
  // R5: idle level whenever the channel was stopped
  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (pwm_out == $past(ctrl.idle_lvl)));
  // R10: capture and reserved modes hold the idle level with a zero counter
  p_capture_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.mode[1]) |-> (pwm_out == $past(ctrl.idle_lvl) && cnt == '0));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] period, duty, cnt;
  logic             run, tick, burst_done;

  pwm_gen_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cnt_live(cnt), .burst_done(burst_done), .period(period), .duty(duty),
    .ctrl(ctrl), .rdata(bus_rdata)
  );

  pwm_gen_tick u_tick (
    .clk(clk), .rst(rst), .run(run), .pre(ctrl.pre), .slow_sel(ctrl.slow_sel),
    .scale(ctrl.scale), .tick(tick)
  );

  pwm_gen_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .period(period), .duty(duty), .tick(tick),
    .run(run), .cnt(cnt), .burst_done(burst_done), .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm_gen_tb.sv
module pwm_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  pwm_gen u_dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  localparam int VN = 8;
  localparam logic [15:0] V_PER  [VN] = '{16'd10, 16'd10, 16'd8, 16'd8, 16'd8, 16'd5, 16'd4, 16'd2};
  localparam logic [15:0] V_DUTY [VN] = '{16'd3, 16'd3, 16'd8, 16'd20, 16'd0, 16'd2, 16'd1, 16'd1};
  localparam logic [31:0] V_CTRL [VN] = '{32'h0000_000B, 32'h0000_0003, 32'h0000_000B, 32'h0000_000B,
                                          32'h0000_000B, 32'h0000_200B, 32'h0003_020B, 32'h0000_020B};
  localparam int          V_HIGH [VN] = '{12, 28, 32, 32, 0, 32, 24, 2048};
  localparam string       V_REQ  [VN] = '{"R3", "R3", "R4", "R4", "R4", "R6", "R7", "R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  function automatic int divisor(input logic [31:0] c);
    int d;
    d = 1 << c[14:12];
    if (c[9]) d = d * ((c[23:16] == 8'd0) ? 512 : 2 * int'(c[23:16]));
    return d;
  endfunction

  task automatic setup(input logic [15:0] p, input logic [15:0] dt, input logic [31:0] c);
    wr(4'h0 + 4'hC, 32'h0);
    wr(4'h4, {16'h0, p});
    wr(4'h8, {16'h0, dt});
    wr(4'hC, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    int hi;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm_out", {31'h0, pwm_out}, 32'h0);
    rd(4'h0, v); check("R1 cnt", v, 32'h0);
    rd(4'h4, v); check("R1 period", v, 32'h0);
    rd(4'h8, v); check("R1 duty", v, 32'h0);
    rd(4'hC, v); check("R1 ctrl", v, 32'h0);

    // R2 readback
    wr(4'h4, 32'h1234_BEEF); rd(4'h4, v); check("R2 period", v, 32'h0000_BEEF);
    wr(4'h8, 32'hFFFF_0042); rd(4'h8, v); check("R2 duty", v, 32'h0000_0042);
    wr(4'hC, 32'h1234_5670); rd(4'hC, v); check("R2 ctrl", v, 32'h1234_5670);

    // table of continuous-mode vectors: on-count over four whole periods
    for (int i = 0; i < VN; i++) begin
      setup(V_PER[i], V_DUTY[i], V_CTRL[i]);
      repeat (3) @(negedge clk);
      count_high(4 * int'(V_PER[i]) * divisor(V_CTRL[i]), hi);
      check(V_REQ[i], hi, V_HIGH[i]);
    end

    // R5 idle level follows bit 4
    wr(4'hC, 32'h0000_0010); repeat (2) @(negedge clk);
    check("R5 idle high", {31'h0, pwm_out}, 32'h1);
    wr(4'hC, 32'h0000_0000); repeat (2) @(negedge clk);
    check("R5 idle low", {31'h0, pwm_out}, 32'h0);

    // R10 capture and reserved modes
    setup(16'd6, 16'd3, 32'h0000_0015);
    count_high(50, hi); check("R10 mode2 idle", hi, 50);
    rd(4'h0, v); check("R10 cnt", v, 32'h0);
    setup(16'd6, 16'd3, 32'h0000_000F);
    count_high(50, hi); check("R10 mode3 idle", hi, 0);

    // R8 one-shot, three periods
    setup(16'd6, 16'd2, 32'h0200_0009);
    count_high(200, hi); check("R8 burst on-count", hi, 6);
    rd(4'hC, v); check("R8 enable cleared", v, 32'h0200_0008);
    check("R8 idle after", {31'h0, pwm_out}, 32'h0);
    setup(16'd6, 16'd2, 32'h0000_0019);
    repeat (30) @(negedge clk);
    check("R8 idle high after", {31'h0, pwm_out}, 32'h1);
    rd(4'hC, v); check("R8 enable cleared 2", v, 32'h0000_0018);

    // R9 on-time change deferred to boundary
    setup(16'd10, 16'd2, 32'h0000_000B);
    repeat (4) @(negedge clk);
    wr(4'h8, 32'd7);
    count_high(6, hi); check("R9 held until wrap", hi, 0);
    repeat (6) @(negedge clk);
    count_high(40, hi); check("R9 new on-time", hi, 28);

    // R11 live counter, writes ignored
    setup(16'd100, 16'd50, 32'h0000_000B);
    repeat (5) @(negedge clk);
    rd(4'h0, c1);
    wr(4'h0, 32'h55);
    rd(4'h0, c2);
    check("R11 counter advance", (c2 + 32'd100 - c1) % 32'd100, 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule